// File: doc/BRIEF.md
# Indexed Real-Time-Clock Register Bank

This block is the host-facing register file of a real-time clock. The host reaches it through two ports. A write to the address port selects one of 64 register indices, and every following access on the data port reads or writes that register until a new index is written. Indices 0 to 9 hold time and alarm bytes and indices 14 to 63 hold general-purpose storage bytes. The bank keeps them as plain byte storage: time counting and rate division live in neighbouring blocks, which read the control fields this bank drives out.

Indices 10 to 13 are the four control registers. The configuration register (index 10) carries a divider field, a periodic-rate field and a live update-in-progress bit that software cannot write. The mode register (index 11) carries the enables and format bits. The status register (index 12) latches update-end, alarm and periodic event pulses and adds a summary request bit that drives the interrupt line. The validity register (index 13) reports that storage and time are valid.

A read of the status register returns the flags and then clears them, which acknowledges the interrupt. An event that arrives on the same clock as that clearing read is kept for the next read.

Top module: `rtc_regbank`

## Requirements
- R1: After reset, index 10 reads {uip_in, 7'h00}, index 11 reads 8'h00, index 12 reads 8'h00, index 13 reads 8'h80, every storage index reads 8'h00, and irq_o is 0.
- R2: A pulse on addr_we selects an index that persists. A data_we pulse writes data_wdata to the selected index. A data_re pulse loads the selected register into data_rdata at that clock edge, and data_rdata holds its value while data_re is low.
- R3: The selected index is the address-port value modulo 64, so 8'h4F selects index 15.
- R4: Index 10 reads {uip_in as sampled on the read clock, stored bits 6:0}. Writes store bits 6:0 only. div_sel drives stored bits 6:4 and rate_sel drives stored bits 3:0.
- R5: Index 11 reads back the byte last written. mode_bits drives it, with these bits: 0 daylight-saving, 1 24-hour, 2 binary, 3 square-wave, 4 update-end enable, 5 alarm enable, 6 periodic enable, 7 set/halt.
- R6: Pulses on upd_evt, alm_evt and per_evt set status bits 4, 5 and 6. They latch whether or not the matching enable is set.
- R7: Status bit 7, and the irq_o output, are 1 whenever any latched flag among bits 6:4 of index 12 has its enable set in the same bit of index 11. Status bits 3:0 read as 0.
- R8: A read of index 12 returns the status and clears the flags on that same edge. An event pulse on that edge leaves its flag set.
- R9: Writes to indices 12 and 13 have no effect. Index 13 always reads 8'h80.
- R10: Indices 0 to 9 and 14 to 63 each store any byte independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_we | input | 1 | Address-port write strobe |
| addr_wdata | input | 8 | Register index (modulo 64) |
| data_we | input | 1 | Data-port write strobe |
| data_re | input | 1 | Data-port read strobe |
| data_wdata | input | 8 | Data-port write value |
| data_rdata | output | 8 | Data-port read value, registered |
| uip_in | input | 1 | Update-in-progress from the time counter |
| upd_evt | input | 1 | Update-end event pulse |
| alm_evt | input | 1 | Alarm match event pulse |
| per_evt | input | 1 | Periodic tick event pulse |
| div_sel | output | 3 | Divider selection field |
| rate_sel | output | 4 | Periodic rate selection field |
| mode_bits | output | 8 | Mode register contents |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench fires an event on the same clock as a clearing status read. A design that lets the clear win would lose that event, and the following read would show zero. It latches flags while their enables are clear and then raises the enable. A design that gates the latch with the enable would never raise irq_o, and one that stores the summary bit would raise it one read late. It writes indices 12, 13 and bit 7 of index 10, and it uses address values above 63. A design that let those writes through would read back the written byte, and one with wrong index wrapping would write the wrong storage byte. Constrained-random traffic mixes all of these with uip_in toggling, to expose a stale or stored update-in-progress bit.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int IDX_CFG   = 10;
    localparam int IDX_MODE  = 11;
    localparam int IDX_STAT  = 12;
    localparam int IDX_VALID = 13;
    // flag vector order: 0 update-end, 1 alarm, 2 periodic
    localparam int NFLAG     = 3;
    localparam int FLAG_LSB  = 4;
    localparam logic [7:0] VALID_VAL = 8'h80;
endpackage

// File: rtl/rtc_store.sv
module rtc_store #(
    parameter int NREG   = 64,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [NREG];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[idx] <= wdata;
        end
    end

    assign rdata = mem_q[idx];
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              mode_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-2:0] cfg_q,
    output logic [DATA_W-1:0] mode_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            mode_q <= '0;
        end else begin
            if (cfg_we)  cfg_q  <= wdata[DATA_W-2:0];
            if (mode_we) mode_q <= wdata;
        end
    end
endmodule

// File: rtl/rtc_evt.sv
module rtc_evt #(
    parameter int NFLAG = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] evt,
    input  logic [NFLAG-1:0] en,
    input  logic             clr,
    output logic [NFLAG-1:0] flags_q,
    output logic             irq
);
    logic [NFLAG-1:0] flags_d;

    always_comb begin
        flags_d = clr ? '0 : flags_q;
        flags_d = flags_d | evt;   // a coincident event survives the clear
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign irq = |(flags_q & en);
endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank #(
    parameter int NREG   = 64,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_we,
    input  logic [DATA_W-1:0] addr_wdata,
    input  logic              data_we,
    input  logic              data_re,
    input  logic [DATA_W-1:0] data_wdata,
    output logic [DATA_W-1:0] data_rdata,
    input  logic              uip_in,
    input  logic              upd_evt,
    input  logic              alm_evt,
    input  logic              per_evt,
    output logic [2:0]        div_sel,
    output logic [3:0]        rate_sel,
    output logic [DATA_W-1:0] mode_bits,
    output logic              irq_o
);
    import rtc_pkg::*;

    logic [IDX_W-1:0]  sel_idx;
    logic [IDX_W-1:0]  idx_wrap;
    logic [DATA_W-2:0] cfg_q;
    logic [DATA_W-1:0] mode_q;
    logic [NFLAG-1:0]  evt_flags;
    logic [DATA_W-1:0] store_rd;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;
    logic              is_ctrl;
    logic              irq_w;

    assign idx_wrap = IDX_W'(addr_wdata % NREG);

    always_ff @(posedge clk) begin
        if (!rst_n)       sel_idx <= '0;
        else if (addr_we) sel_idx <= idx_wrap;
    end

    assign is_ctrl = (sel_idx >= IDX_W'(IDX_CFG)) && (sel_idx <= IDX_W'(IDX_VALID));

    rtc_store #(.NREG(NREG), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (data_we && !is_ctrl),
        .idx   (sel_idx),
        .wdata (data_wdata),
        .rdata (store_rd)
    );

    rtc_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (data_we && sel_idx == IDX_W'(IDX_CFG)),
        .mode_we (data_we && sel_idx == IDX_W'(IDX_MODE)),
        .wdata   (data_wdata),
        .cfg_q   (cfg_q),
        .mode_q  (mode_q)
    );

    rtc_evt #(.NFLAG(NFLAG)) u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     ({per_evt, alm_evt, upd_evt}),
        .en      (mode_q[FLAG_LSB +: NFLAG]),
        .clr     (data_re && sel_idx == IDX_W'(IDX_STAT)),
        .flags_q (evt_flags),
        .irq     (irq_w)
    );

    always_comb begin
        unique case (sel_idx)
            IDX_W'(IDX_CFG):   rd_mux = {uip_in, cfg_q};
            IDX_W'(IDX_MODE):  rd_mux = mode_q;
            IDX_W'(IDX_STAT):  rd_mux = {irq_w, evt_flags, 4'b0000};
            IDX_W'(IDX_VALID): rd_mux = VALID_VAL;
            default:           rd_mux = store_rd;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= '0;
        else if (data_re) rdata_q <= rd_mux;
    end

    assign data_rdata = rdata_q;
    assign div_sel    = cfg_q[6:4];
    assign rate_sel   = cfg_q[3:0];
    assign mode_bits  = mode_q;
    assign irq_o      = irq_w;
endmodule

// File: rtl/rtc_regbank_chk.sv
module rtc_regbank_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       data_re,
    input logic       data_we,
    input logic       uip_in,
    input logic       upd_evt,
    input logic       alm_evt,
    input logic       per_evt,
    input logic [7:0] data_rdata,
    input logic       irq_o,
    input logic [5:0] sel_idx,
    input logic [2:0] evt_flags
);
    assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !data_re |=> $stable(data_rdata));

    assert_uip_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_re && sel_idx == 6'd10) |=> data_rdata[7] == $past(uip_in));

    assert_latch_upd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_evt |=> evt_flags[0]);

    assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(upd_evt || alm_evt || per_evt || data_we));

    assert_clear_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_re && sel_idx == 6'd12 && !(upd_evt || alm_evt || per_evt))
        |=> (evt_flags == 3'b000 && !irq_o));

    assert_valid_const_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (data_re && sel_idx == 6'd13) |=> data_rdata == 8'h80);
endmodule

bind rtc_regbank rtc_regbank_chk u_chk (.*);

// File: tb/tb_rtc_regbank.sv
module tb_rtc_regbank;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       addr_we = 0, data_we = 0, data_re = 0;
    logic [7:0] addr_wdata = 0, data_wdata = 0;
    logic [7:0] data_rdata;
    logic       uip_in = 0, upd_evt = 0, alm_evt = 0, per_evt = 0;
    logic [2:0] div_sel;
    logic [3:0] rate_sel;
    logic [7:0] mode_bits;
    logic       irq_o;

    always #5 clk = ~clk;

    rtc_regbank dut (.*);

    int checks = 0, fails = 0;
    bit done = 0;

    // bench model
    logic [7:0] m_mem [64];
    logic [6:0] m_cfg;
    logic [7:0] m_mode;
    logic [2:0] m_flags;
    logic [5:0] m_idx;

    function automatic logic m_irq();
        return |(m_flags & m_mode[6:4]);
    endfunction

    function automatic logic [7:0] m_read(logic uip);
        case (m_idx)
            6'd10:   return {uip, m_cfg};
            6'd11:   return m_mode;
            6'd12:   return {m_irq(), m_flags, 4'b0000};
            6'd13:   return 8'h80;
            default: return m_mem[m_idx];
        endcase
    endfunction

    function automatic string tag_of(logic [5:0] i);
        case (i)
            6'd10:   return "R4";
            6'd11:   return "R5";
            6'd12:   return "R8";
            6'd13:   return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // op: 0 address write, 1 data write, 2 data read, 3 idle
    task automatic step(int op, logic [7:0] v, logic [2:0] ev, logic uip, string req);
        logic [7:0] exp_rd;
        addr_we = (op == 0); data_we = (op == 1); data_re = (op == 2);
        addr_wdata = v; data_wdata = v; uip_in = uip;
        {per_evt, alm_evt, upd_evt} = ev;
        exp_rd = m_read(uip);
        @(negedge clk);
        if (op == 0) m_idx = v[5:0];
        if (op == 1) begin
            if (m_idx == 6'd10)      m_cfg = v[6:0];
            else if (m_idx == 6'd11) m_mode = v;
            else if (m_idx < 6'd10 || m_idx > 6'd13) m_mem[m_idx] = v;
        end
        if (op == 2 && m_idx == 6'd12) m_flags = 3'b000;
        m_flags = m_flags | ev;
        if (op == 2) check(req == "" ? tag_of(m_idx) : req, data_rdata, exp_rd);
        check("R7 irq", {7'd0, irq_o}, {7'd0, m_irq()});
        check("R4 fields", {1'b0, div_sel, rate_sel}, {1'b0, m_cfg});
        check("R5 mode", mode_bits, m_mode);
        addr_we = 0; data_we = 0; data_re = 0;
        {per_evt, alm_evt, upd_evt} = 3'b000;
    endtask

    task automatic sel(logic [7:0] a); step(0, a, 3'b000, 1'b0, ""); endtask
    task automatic wr(logic [7:0] d); step(1, d, 3'b000, 1'b0, ""); endtask
    task automatic rd(string r); step(2, 8'h00, 3'b000, 1'b0, r); endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) m_mem[i] = 8'h00;
        m_cfg = 0; m_mode = 0; m_flags = 0; m_idx = 0;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", {7'd0, irq_o}, 8'd0);
        for (int i = 10; i < 14; i++) begin sel(8'(i)); rd("R1"); end
        sel(8'd10); step(2, 8'h00, 3'b000, 1'b1, "R1");
        sel(8'd20); rd("R1");

        // R2/R10 plain write and read, index persists
        sel(8'd3); wr(8'hA5); rd("R2"); rd("R2");
        sel(8'd63); wr(8'h3C); rd("R10");

        // R3 wrap: 0x4F selects 15
        sel(8'h4F); wr(8'h77); sel(8'd15); rd("R3");
        sel(8'hC0); rd("R3");

        // R4 bit 7 ignored, R9 writes to 12 and 13 ignored
        sel(8'd10); wr(8'hFF); rd("R4");
        sel(8'd12); wr(8'hFF); rd("R9");
        sel(8'd13); wr(8'h00); rd("R9");

        // R6 latch with enables clear, then R7 enable raises irq
        step(3, 8'h00, 3'b111, 1'b0, "");
        sel(8'd11); wr(8'h20);
        check("R7 enable after latch", {7'd0, irq_o}, 8'd1);
        sel(8'd12); rd("R6");
        check("R8 cleared irq", {7'd0, irq_o}, 8'd0);

        // R8 event coincident with clearing read
        step(3, 8'h00, 3'b010, 1'b0, "");
        step(2, 8'h00, 3'b010, 1'b0, "R8");
        rd("R8"); rd("R8");

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            int op;
            logic [7:0] v;
            op = $urandom_range(0, 3);
            v  = 8'($urandom);
            step(op, v, 3'($urandom) & 3'($urandom), 1'($urandom), "");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule